// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block follows the operating mode of a small processor core across its power states: full-speed operation, slow operation on the subclock, sleep on the subclock, a watch state in which the core is halted, and a hardware-forced standby state. A reset state is also tracked. Each cycle the block takes a strobe from the core's sleep instruction, a strobe for a pending interrupt, the active-low reset and standby pins, and a set of configuration bits. The four control bits are sampled when a sleep strobe arrives, and their values pick the next mode.

The mode sits in a single register. The clock select, the core run enable, the per-peripheral clock gates, the effective clock divider and a configuration-error flag are all decoded from that register. In the slow modes, only the two watchdog timers keep their clocks. A direct return from slow operation to full speed forces the divider to zero. The divider is held at zero until software has written zero to the divider field.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high, `mode_o` is RESET (code 0), and `cpu_run_o`, `clk_sub_o` and all of `periph_gate_o` are 0. RESET moves to HIGH (code 1) at the first edge where both `res_n_i` and `stby_n_i` are high.
- R2: In HIGH, a sleep strobe with `stby_sel_i`=1, `direct_en_i`=1, `lowspd_i`=1 and `psel_i`=1 moves the mode to SUBACT (code 2) at the next edge.
- R3: In SUBACT, a sleep strobe with `stby_sel_i`=1, `direct_en_i`=0 and `psel_i`=1 moves the mode to WATCH (code 4).
- R4: In SUBACT, a sleep strobe with `stby_sel_i`=0, `lowspd_i`=1 and `psel_i`=1 moves the mode to SUBSLP (code 3).
- R5: In SUBACT, a sleep strobe with `stby_sel_i`=1, `direct_en_i`=1, `lowspd_i`=0 and `psel_i`=1 moves the mode to HIGH. After that, `div_o` reads 0 until a cycle in HIGH where `div_i` is 0. From then on, `div_o` follows `div_i` while in HIGH.
- R6: In WATCH, an interrupt strobe with `lowspd_i`=1 moves the mode to SUBACT. With `lowspd_i`=0, the mode stays WATCH.
- R7: In SUBSLP, any interrupt strobe moves the mode to SUBACT.
- R8: A low `stby_n_i` moves any mode to HWSTBY (code 5) at the next edge, even when `res_n_i` is also low. HWSTBY is left only through a low `res_n_i`.
- R9: A low `res_n_i` with `stby_n_i` high moves any mode to RESET at the next edge. This takes priority over sleep and interrupt strobes.
- R10: `clk_sub_o` is 1 exactly in SUBACT, SUBSLP and WATCH. `cpu_run_o` is 1 exactly in HIGH and SUBACT.
- R11: `periph_gate_o` is all ones in HIGH. In SUBACT, SUBSLP and WATCH, only bits 0 and 1 (the two watchdogs) are set. In RESET and HWSTBY it is all zeros.
- R12: `cfg_err_o` is 1 exactly when the mode is SUBACT and `div_i` is nonzero.
- R13: A sleep strobe whose control bits match none of the transitions above leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| sleep_i | input | 1 | One-cycle sleep instruction strobe |
| irq_i | input | 1 | One-cycle interrupt pending strobe |
| res_n_i | input | 1 | Reset pin, active low |
| stby_n_i | input | 1 | Standby pin, active low |
| stby_sel_i | input | 1 | Standby select control bit |
| direct_en_i | input | 1 | Direct transition enable bit |
| lowspd_i | input | 1 | Low-speed-on select bit |
| psel_i | input | 1 | Watchdog prescaler select bit |
| div_i | input | 3 | Programmed system clock divider |
| mode_o | output | 3 | Current mode code |
| clk_sub_o | output | 1 | 1 selects the subclock for the CPU |
| cpu_run_o | output | 1 | CPU run enable |
| periph_gate_o | output | NPER | Per-peripheral clock enables; bits 0 and 1 are the watchdogs |
| div_o | output | 3 | Effective clock divider |
| cfg_err_o | output | 1 | Nonzero divider while in SUBACT |

## Verification
On every cycle, the assertions check the pin-driven paths: a low standby pin leads to HWSTBY and a low reset pin leads to RESET. They also check that the core is halted in the sleeping modes, that only the watchdog gates stay open in SUBACT, that a direct return leaves the divider at zero, and that a configuration error only shows while the core runs on the subclock. Only the bench scenarios can show the full mode sequences, with their ordering. These cover sleep, then interrupt, then a return to SUBACT. They also cover control-bit combinations that must leave the mode alone, the release of the divider hold once software writes zero, and a HWSTBY state that the standby pin alone cannot release.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        M_RESET  = 3'd0,
        M_HIGH   = 3'd1,
        M_SUBACT = 3'd2,
        M_SUBSLP = 3'd3,
        M_WATCH  = 3'd4,
        M_HWSTBY = 3'd5
    } mode_t;

    typedef struct packed {
        logic stby_sel;
        logic direct_en;
        logic lowspd;
        logic psel;
    } ctl_t;

    localparam int DIV_W   = 3;
    localparam int WDT_LO  = 0;
    localparam int WDT_HI  = 1;

    function automatic logic is_watchdog(input int idx);
        return (idx == WDT_LO) || (idx == WDT_HI);
    endfunction

    function automatic logic is_slow(input mode_t m);
        return (m == M_SUBACT) || (m == M_SUBSLP) || (m == M_WATCH);
    endfunction

endpackage

// File: rtl/lpm_next_state.sv
module lpm_next_state
    import lpm_pkg::*;
(
    input  mode_t cur,
    input  logic  sleep,
    input  logic  irq,
    input  logic  res_n,
    input  logic  stby_n,
    input  ctl_t  ctl,
    output mode_t nxt,
    output logic  direct_hit
);

    logic to_sub, to_watch, to_subslp, to_direct;

    always_comb begin
        to_sub    = ctl.stby_sel & ctl.direct_en & ctl.lowspd & ctl.psel;
        to_watch  = ctl.stby_sel & ~ctl.direct_en & ctl.psel;
        to_subslp = ~ctl.stby_sel & ctl.lowspd & ctl.psel;
        to_direct = ctl.stby_sel & ctl.direct_en & ~ctl.lowspd & ctl.psel;
    end

    always_comb begin
        nxt        = cur;
        direct_hit = 1'b0;
        if (!stby_n) begin
            nxt = M_HWSTBY;
        end else if (!res_n) begin
            nxt = M_RESET;
        end else begin
            unique case (cur)
                M_RESET:  nxt = M_HIGH;
                M_HIGH:   if (sleep && to_sub) nxt = M_SUBACT;
                M_SUBACT: if (sleep) begin
                    if (to_watch)       nxt = M_WATCH;
                    else if (to_subslp) nxt = M_SUBSLP;
                    else if (to_direct) begin
                        nxt        = M_HIGH;
                        direct_hit = 1'b1;
                    end
                end
                M_WATCH:  if (irq && ctl.lowspd) nxt = M_SUBACT;
                M_SUBSLP: if (irq) nxt = M_SUBACT;
                M_HWSTBY: nxt = M_HWSTBY;
                default:  nxt = M_RESET;
            endcase
        end
    end

endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
    import lpm_pkg::*;
#(
    parameter int NPER = 8
) (
    input  mode_t            mode,
    input  logic [DIV_W-1:0] div_req,
    input  logic             div_hold,
    output logic             clk_sub,
    output logic             cpu_run,
    output logic [NPER-1:0]  gate,
    output logic [DIV_W-1:0] div_eff,
    output logic             cfg_err
);

    logic slow, fast;

    always_comb begin
        slow    = is_slow(mode);
        fast    = (mode == M_HIGH);
        clk_sub = slow;
        cpu_run = fast || (mode == M_SUBACT);
        cfg_err = (mode == M_SUBACT) && (div_req != '0);
        div_eff = (fast && !div_hold) ? div_req : '0;
    end

    for (genvar g = 0; g < NPER; g++) begin : g_gate
        if (is_watchdog(g)) begin : g_wdt
            assign gate[g] = fast | slow;
        end else begin : g_other
            assign gate[g] = fast;
        end
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NPER = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep_i,
    input  logic            irq_i,
    input  logic            res_n_i,
    input  logic            stby_n_i,
    input  logic            stby_sel_i,
    input  logic            direct_en_i,
    input  logic            lowspd_i,
    input  logic            psel_i,
    input  logic [2:0]      div_i,
    output logic [2:0]      mode_o,
    output logic            clk_sub_o,
    output logic            cpu_run_o,
    output logic [NPER-1:0] periph_gate_o,
    output logic [2:0]      div_o,
    output logic            cfg_err_o
);

    mode_t mode_q, mode_d;
    ctl_t  ctl;
    logic  direct_hit;
    logic  hold_q;

    assign ctl = '{stby_sel: stby_sel_i, direct_en: direct_en_i,
                   lowspd: lowspd_i, psel: psel_i};

    lpm_next_state i_next (
        .cur        (mode_q),
        .sleep      (sleep_i),
        .irq        (irq_i),
        .res_n      (res_n_i),
        .stby_n     (stby_n_i),
        .ctl        (ctl),
        .nxt        (mode_d),
        .direct_hit (direct_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_RESET;
            hold_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (direct_hit)
                hold_q <= 1'b1;
            else if (mode_q == M_HIGH && div_i == '0)
                hold_q <= 1'b0;
        end
    end

    lpm_out_decode #(.NPER(NPER)) i_dec (
        .mode     (mode_q),
        .div_req  (div_i),
        .div_hold (hold_q),
        .clk_sub  (clk_sub_o),
        .cpu_run  (cpu_run_o),
        .gate     (periph_gate_o),
        .div_eff  (div_o),
        .cfg_err  (cfg_err_o)
    );

    assign mode_o = mode_q;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int NPER = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            sleep_i,
    input logic            res_n_i,
    input logic            stby_n_i,
    input logic            stby_sel_i,
    input logic            direct_en_i,
    input logic            lowspd_i,
    input logic            psel_i,
    input logic [2:0]      mode_o,
    input logic            clk_sub_o,
    input logic            cpu_run_o,
    input logic [NPER-1:0] periph_gate_o,
    input logic [2:0]      div_o,
    input logic            cfg_err_o
);

    localparam logic [NPER-1:0] WDT_MASK = NPER'(2'b11);

    p_stby_wins_r8: assert property (@(posedge clk) disable iff (rst)
        !stby_n_i |=> mode_o == 3'd5);

    p_reset_pin_r9: assert property (@(posedge clk) disable iff (rst)
        (stby_n_i && !res_n_i) |=> mode_o == 3'd0);

    p_halt_when_asleep_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd3 || mode_o == 3'd4 || mode_o == 3'd5) |-> !cpu_run_o);

    p_wdt_only_r11: assert property (@(posedge clk) disable iff (rst)
        mode_o == 3'd2 |-> periph_gate_o == WDT_MASK);

    p_direct_div_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd2 && sleep_i && stby_sel_i && direct_en_i && !lowspd_i
         && psel_i && stby_n_i && res_n_i) |=> (mode_o == 3'd1 && div_o == 3'd0));

    p_err_on_sub_r12: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |-> (clk_sub_o && cpu_run_o));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NPER(NPER)) i_lpm_ctrl_chk (.*);

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;

    localparam int NPER = 8;
    localparam logic [2:0] C_RESET = 3'd0, C_HIGH = 3'd1, C_SUBACT = 3'd2,
                           C_SUBSLP = 3'd3, C_WATCH = 3'd4, C_HWSTBY = 3'd5;

    logic clk = 1'b0;
    logic rst, sleep_i, irq_i, res_n_i, stby_n_i;
    logic stby_sel_i, direct_en_i, lowspd_i, psel_i;
    logic [2:0] div_i, mode_o, div_o;
    logic clk_sub_o, cpu_run_o, cfg_err_o;
    logic [NPER-1:0] periph_gate_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lpm_ctrl #(.NPER(NPER)) i_lpm_ctrl (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic s, input logic d, input logic l, input logic p);
        stby_sel_i = s; direct_en_i = d; lowspd_i = l; psel_i = p;
    endtask

    task automatic do_sleep(input logic s, input logic d, input logic l, input logic p);
        set_ctl(s, d, l, p);
        sleep_i = 1'b1;
        @(negedge clk);
        sleep_i = 1'b0;
    endtask

    task automatic do_irq();
        irq_i = 1'b1;
        @(negedge clk);
        irq_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; res_n_i = 1'b1; stby_n_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 mode in reset", mode_o, C_RESET);
        check("R1 run in reset", cpu_run_o, 0);
        check("R11 gates in reset", periph_gate_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset to high", mode_o, C_HIGH);
        check("R10 run in high", cpu_run_o, 1);
        check("R10 main clock in high", clk_sub_o, 0);
        check("R11 gates in high", periph_gate_o, 8'hFF);
    endtask

    task automatic t_enter_sub();
        do_sleep(1'b0, 1'b1, 1'b1, 1'b1);
        check("R13 unmatched sleep in high", mode_o, C_HIGH);
        do_sleep(1'b1, 1'b1, 1'b1, 1'b1);
        check("R2 high to subact", mode_o, C_SUBACT);
        check("R10 subclock in subact", clk_sub_o, 1);
        check("R10 run in subact", cpu_run_o, 1);
        check("R11 watchdog gates only", periph_gate_o, 8'h03);
        check("R12 no error with zero divider", cfg_err_o, 0);
        div_i = 3'd3;
        #1;
        check("R12 error with nonzero divider", cfg_err_o, 1);
        div_i = 3'd0;
        #1;
    endtask

    task automatic t_watch();
        do_sleep(1'b1, 1'b0, 1'b0, 1'b1);
        check("R3 subact to watch", mode_o, C_WATCH);
        check("R10 halted in watch", cpu_run_o, 0);
        lowspd_i = 1'b0;
        do_irq();
        check("R6 irq ignored with low-speed off", mode_o, C_WATCH);
        lowspd_i = 1'b1;
        do_irq();
        check("R6 watch to subact", mode_o, C_SUBACT);
    endtask

    task automatic t_subsleep();
        do_sleep(1'b0, 1'b0, 1'b1, 1'b1);
        check("R4 subact to subsleep", mode_o, C_SUBSLP);
        check("R10 halted in subsleep", cpu_run_o, 0);
        check("R11 watchdog gates in subsleep", periph_gate_o, 8'h03);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        do_irq();
        check("R7 subsleep to subact", mode_o, C_SUBACT);
    endtask

    task automatic t_unmatched();
        do_sleep(1'b1, 1'b1, 1'b0, 1'b0);
        check("R13 unmatched sleep in subact", mode_o, C_SUBACT);
    endtask

    task automatic t_direct();
        div_i = 3'd5;
        do_sleep(1'b1, 1'b1, 1'b0, 1'b1);
        check("R5 direct return to high", mode_o, C_HIGH);
        check("R5 divider forced zero", div_o, 0);
        @(negedge clk);
        check("R5 divider still held", div_o, 0);
        div_i = 3'd0;
        @(negedge clk);
        div_i = 3'd6;
        #1;
        check("R5 divider released", div_o, 6);
        div_i = 3'd0;
    endtask

    task automatic t_standby();
        stby_n_i = 1'b0; res_n_i = 1'b0;
        @(negedge clk);
        check("R8 standby beats reset pin", mode_o, C_HWSTBY);
        check("R11 gates off in standby", periph_gate_o, 0);
        check("R10 halted in standby", cpu_run_o, 0);
        stby_n_i = 1'b1; res_n_i = 1'b1;
        @(negedge clk);
        check("R8 standby held after pin release", mode_o, C_HWSTBY);
        res_n_i = 1'b0;
        @(negedge clk);
        check("R8 reset pin leaves standby", mode_o, C_RESET);
        res_n_i = 1'b1;
        @(negedge clk);
        check("R1 back to high", mode_o, C_HIGH);
    endtask

    task automatic t_reset_prio();
        do_sleep(1'b1, 1'b1, 1'b1, 1'b1);
        check("R2 subact again", mode_o, C_SUBACT);
        res_n_i = 1'b0;
        do_sleep(1'b1, 1'b0, 1'b0, 1'b1);
        check("R9 reset pin beats sleep", mode_o, C_RESET);
        res_n_i = 1'b1;
        @(negedge clk);
        check("R9 recovered to high", mode_o, C_HIGH);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; sleep_i = 1'b0; irq_i = 1'b0;
        res_n_i = 1'b1; stby_n_i = 1'b1; div_i = 3'd0;
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        t_reset();
        t_enter_sub();
        t_watch();
        t_subsleep();
        t_unmatched();
        t_direct();
        t_standby();
        t_reset_prio();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule